// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves relative control transfers for an 8-bit processor core. It is given one instruction: its opcode, up to two operand bytes, the address of the opcode, the four condition flags (negative, overflow, zero, carry) and, for bit-test branches, the memory byte that the core has already fetched. From these it decides whether the branch is taken and which program counter comes next. For a branch-to-subroutine it also raises a request to push a return address. Fetching the tested byte and writing the stack are left to the surrounding core.

Three families of branch are recognised. Short branches carry a signed 8-bit offset. Long branches carry a 16-bit offset and test the same conditions. Bit-test branches check one bit of a memory byte. The result is registered and appears one clock after the instruction is presented. Parameters size the address path and let a build leave out the long-offset or bit-test families.

Top module: `brc_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, out_valid, is_branch, taken and push_req are 0 and next_pc is 0.
- R2: Each output appears exactly one clock after the instruction is presented with in_valid high. out_valid follows in_valid with a delay of one cycle. When out_valid is 0, taken, push_req and is_branch are all 0.
- R3: Short conditional branches have low nibble 0 and an odd high nibble. The high nibble picks the test: 1 is N clear, 3 is N set, 5 is V clear, 7 is V set, 9 is C clear, B is C set, D is Z clear, F is Z set. taken is 1 exactly when the test holds.
- R4: For a short branch (including $80), a taken result gives next_pc = op_addr + 2 + the sign-extended opnd_lo. A short branch that is not taken gives op_addr + 2.
- R5: Long branches use the same high nibbles with low nibble 3 and the same tests. A taken result gives next_pc = op_addr + 2 + {opnd_hi, opnd_lo}. A long branch that is not taken gives op_addr + 3.
- R6: Opcodes $80 (short) and $83 (long) are always taken, whatever the flags.
- R7: Opcode $63 (branch-to-subroutine) is always taken. Its target is computed as in R5. It raises push_req, and ret_addr = op_addr + 2.
- R8: Bit-test branches have low nibble F. They test bit opcode[6:4] of test_byte and branch when that bit equals opcode[7] (0 means branch if clear, 1 means branch if set). When taken, next_pc = op_addr + 3 + the sign-extended opnd_hi. When not taken, next_pc = op_addr + 3.
- R9: Any other opcode gives is_branch = 0, taken = 0, push_req = 0 and next_pc = op_addr. The flags and test_byte have no effect on it.
- R10: All target and sequential addresses wrap modulo 2^ADDR_W, which is 65536 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| opcode | input | 8 | Instruction opcode |
| opnd_lo | input | 8 | First byte after the opcode |
| opnd_hi | input | 8 | Second byte after the opcode |
| op_addr | input | ADDR_W | Address of the opcode |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| test_byte | input | 8 | Memory byte examined by bit-test branches |
| out_valid | output | 1 | Result valid |
| is_branch | output | 1 | Opcode was recognised as a branch |
| taken | output | 1 | Branch taken |
| next_pc | output | ADDR_W | Next program counter |
| push_req | output | 1 | Request to push a return address |
| ret_addr | output | ADDR_W | Return address for push_req |

## Verification
The bench sweeps all 256 opcodes against several flag patterns and test bytes. This catches a decoder that admits a non-branch opcode, or that swaps the flag or sense of a test. A wrong flag mapping would show up as an inverted taken bit on one condition pair. Offsets of +127 and -128 near both ends of the address space check that sign extension and the modulo wrap are right; a zero-extending adder would land 256 bytes away. The bench also checks that long branches take their offset from op_addr + 2 but fall through to op_addr + 3, that bit-test branches take their offset from the third byte, and that $63 alone requests a push. Using the wrong base for either family moves next_pc by one. Idle cycles placed between instructions show whether the outputs stay quiet when no instruction is presented.

// File: rtl/brc_pkg.sv
package brc_pkg;

   typedef enum logic [1:0] {
      K_NONE  = 2'd0,
      K_SHORT = 2'd1,
      K_LONG  = 2'd2,
      K_BIT   = 2'd3
   } br_kind_e;

   typedef struct packed {
      br_kind_e   kind;
      logic       uncond;
      logic       is_call;
      logic [1:0] flag_sel;   // 00 N, 01 V, 10 C, 11 Z
      logic       flag_sense; // 1: branch when flag set
      logic [2:0] bit_idx;
      logic       bit_sense;  // 1: branch when bit set
   } br_dec_t;

   localparam logic [7:0] OP_BRA_S = 8'h80;
   localparam logic [7:0] OP_BRA_L = 8'h83;
   localparam logic [7:0] OP_CALL  = 8'h63;

endpackage

// File: rtl/brc_decode.sv
module brc_decode
   import brc_pkg::*;
#(
   parameter bit LONG_EN = 1'b1,
   parameter bit BIT_EN  = 1'b1
) (
   input  logic [7:0] opcode,
   output br_dec_t    dec
);

   logic [3:0] lo_nib;
   logic       short_hit;
   logic       long_hit;
   logic       bit_hit;

   assign lo_nib    = opcode[3:0];
   assign short_hit = (lo_nib == 4'h0) && (opcode[4] || opcode == OP_BRA_S);

   generate
      if (LONG_EN) begin : g_long
         assign long_hit = (lo_nib == 4'h3) &&
                           (opcode[4] || opcode == OP_BRA_L || opcode == OP_CALL);
      end else begin : g_no_long
         assign long_hit = 1'b0;
      end
      if (BIT_EN) begin : g_bit
         assign bit_hit = (lo_nib == 4'hF);
      end else begin : g_no_bit
         assign bit_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      dec            = '0;
      dec.kind       = K_NONE;
      dec.flag_sel   = opcode[7:6];
      dec.flag_sense = opcode[5];
      dec.bit_idx    = opcode[6:4];
      dec.bit_sense  = opcode[7];
      if (short_hit) begin
         dec.kind   = K_SHORT;
         dec.uncond = (opcode == OP_BRA_S);
      end else if (long_hit) begin
         dec.kind    = K_LONG;
         dec.uncond  = (opcode == OP_BRA_L) || (opcode == OP_CALL);
         dec.is_call = (opcode == OP_CALL);
      end else if (bit_hit) begin
         dec.kind = K_BIT;
      end
   end

   // R7: a call decode is always an unconditional long branch
   always_comb begin
      if (dec.is_call) begin
         p_call_is_long_r7: assert (dec.uncond && dec.kind == K_LONG);
      end
   end

endmodule

// File: rtl/brc_cond.sv
module brc_cond
   import brc_pkg::*;
(
   input  br_dec_t    dec,
   input  logic       flag_n,
   input  logic       flag_v,
   input  logic       flag_z,
   input  logic       flag_c,
   input  logic [7:0] test_byte,
   output logic       take
);

   logic flag_val;
   logic flag_ok;
   logic bit_ok;

   always_comb begin
      unique case (dec.flag_sel)
         2'b00:   flag_val = flag_n;
         2'b01:   flag_val = flag_v;
         2'b10:   flag_val = flag_c;
         default: flag_val = flag_z;
      endcase
   end

   assign flag_ok = dec.uncond || (flag_val == dec.flag_sense);
   assign bit_ok  = (test_byte[dec.bit_idx] == dec.bit_sense);

   always_comb begin
      unique case (dec.kind)
         K_SHORT, K_LONG: take = flag_ok;
         K_BIT:           take = bit_ok;
         default:         take = 1'b0;
      endcase
   end

   // R9: an unrecognised opcode never yields a taken branch
   always_comb begin
      if (dec.kind == K_NONE) begin
         p_none_not_taken_r9: assert (!take);
      end
   end

endmodule

// File: rtl/brc_target.sv
module brc_target
   import brc_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  br_dec_t           dec,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [7:0]        opnd_lo,
   input  logic [7:0]        opnd_hi,
   output logic [ADDR_W-1:0] tgt_pc,
   output logic [ADDR_W-1:0] seq_pc,
   output logic [ADDR_W-1:0] ret_pc
);

   localparam int          SX8_W = ADDR_W - 8;
   localparam logic [ADDR_W-1:0] TWO   = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] THREE = ADDR_W'(3);

   logic [ADDR_W-1:0] off_s8_lo;
   logic [ADDR_W-1:0] off_s8_hi;
   logic [ADDR_W-1:0] off_long;
   logic [ADDR_W-1:0] base_pc;
   logic [ADDR_W-1:0] off_pick;
   logic [ADDR_W-1:0] pc_p2;
   logic [ADDR_W-1:0] pc_p3;

   assign off_s8_lo = {{SX8_W{opnd_lo[7]}}, opnd_lo};
   assign off_s8_hi = {{SX8_W{opnd_hi[7]}}, opnd_hi};

   generate
      if (ADDR_W == 16) begin : g_w16
         assign off_long = {opnd_hi, opnd_lo};
      end else begin : g_wide
         assign off_long = {{(ADDR_W-16){opnd_hi[7]}}, opnd_hi, opnd_lo};
      end
   endgenerate

   assign pc_p2 = op_addr + TWO;
   assign pc_p3 = op_addr + THREE;

   always_comb begin
      unique case (dec.kind)
         K_SHORT: begin base_pc = pc_p2; off_pick = off_s8_lo; seq_pc = pc_p2;   end
         K_LONG:  begin base_pc = pc_p2; off_pick = off_long;  seq_pc = pc_p3;   end
         K_BIT:   begin base_pc = pc_p3; off_pick = off_s8_hi; seq_pc = pc_p3;   end
         default: begin base_pc = op_addr; off_pick = '0;      seq_pc = op_addr; end
      endcase
   end

   assign tgt_pc = base_pc + off_pick;
   assign ret_pc = pc_p2;

endmodule

// File: rtl/brc_unit.sv
module brc_unit
   import brc_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter bit LONG_EN = 1'b1,
   parameter bit BIT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        opcode,
   input  logic [7:0]        opnd_lo,
   input  logic [7:0]        opnd_hi,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              flag_n,
   input  logic              flag_v,
   input  logic              flag_z,
   input  logic              flag_c,
   input  logic [7:0]        test_byte,
   output logic              out_valid,
   output logic              is_branch,
   output logic              taken,
   output logic [ADDR_W-1:0] next_pc,
   output logic              push_req,
   output logic [ADDR_W-1:0] ret_addr
);

   generate
      if (ADDR_W < 16) begin : g_bad_width
         $error("brc_unit: ADDR_W must be at least 16");
      end
   endgenerate

   br_dec_t           dec;
   logic              take_c;
   logic [ADDR_W-1:0] tgt_c;
   logic [ADDR_W-1:0] seq_c;
   logic [ADDR_W-1:0] ret_c;

   brc_decode #(.LONG_EN(LONG_EN), .BIT_EN(BIT_EN)) u_dec (
      .opcode (opcode),
      .dec    (dec)
   );

   brc_cond u_cond (
      .dec       (dec),
      .flag_n    (flag_n),
      .flag_v    (flag_v),
      .flag_z    (flag_z),
      .flag_c    (flag_c),
      .test_byte (test_byte),
      .take      (take_c)
   );

   brc_target #(.ADDR_W(ADDR_W)) u_tgt (
      .dec     (dec),
      .op_addr (op_addr),
      .opnd_lo (opnd_lo),
      .opnd_hi (opnd_hi),
      .tgt_pc  (tgt_c),
      .seq_pc  (seq_c),
      .ret_pc  (ret_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         is_branch <= 1'b0;
         taken     <= 1'b0;
         next_pc   <= '0;
         push_req  <= 1'b0;
         ret_addr  <= '0;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         is_branch <= (dec.kind != K_NONE);
         taken     <= take_c;
         next_pc   <= take_c ? tgt_c : seq_c;
         push_req  <= dec.is_call;
         ret_addr  <= dec.is_call ? ret_c : '0;
      end else begin
         out_valid <= 1'b0;
         is_branch <= 1'b0;
         taken     <= 1'b0;
         push_req  <= 1'b0;
      end
   end

   // R2: output valid trails input valid by one cycle
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2: idle output carries no branch decision
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!taken && !push_req && !is_branch));

   // R6: unconditional opcodes are always taken
   p_bra_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opcode == OP_BRA_S || (LONG_EN && opcode == OP_BRA_L))) |=> taken);

   // R7: a push request only accompanies a taken branch
   p_call_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push_req |-> (taken && is_branch));

   // R9: a non-branch leaves the program counter on the opcode address
   p_nonbranch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !is_branch) |-> (!taken && next_pc == $past(op_addr)));

endmodule

// File: tb/sim_brc_unit.sv
`timescale 1ns/1ps
module sim_brc_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [7:0]  opcode, opnd_lo, opnd_hi, test_byte;
   logic [15:0] op_addr;
   logic        flag_n, flag_v, flag_z, flag_c;
   logic        out_valid, is_branch, taken, push_req;
   logic [15:0] next_pc, ret_addr;

   always #2.5 clk = ~clk;

   brc_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .op_addr(op_addr),
      .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
      .test_byte(test_byte), .out_valid(out_valid), .is_branch(is_branch),
      .taken(taken), .next_pc(next_pc), .push_req(push_req), .ret_addr(ret_addr)
   );

   typedef struct {
      bit    vld;
      bit    br;
      bit    tk;
      bit    push;
      int    nxt;
      int    ret;
      string tk_tag;
      string pc_tag;
   } exp_t;

   exp_t pend[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic exp_t model(bit v, logic [7:0] op, logic [7:0] lo, logic [7:0] hi,
                                  int addr, bit n, bit ov, bit z, bit c, logic [7:0] tb);
      exp_t e;
      int   off, raw;
      bit   cond;
      e = '{vld: v, br: 0, tk: 0, push: 0, nxt: 0, ret: 0, tk_tag: "R2", pc_tag: "R2"};
      if (!v) return e;
      case (op[7:4])
         4'h1: cond = !n;   4'h3: cond = n;
         4'h5: cond = !ov;  4'h7: cond = ov;
         4'h9: cond = !c;   4'hB: cond = c;
         4'hD: cond = !z;   4'hF: cond = z;
         default: cond = 0;
      endcase
      if (op == 8'h80 || op == 8'h83 || op == 8'h63) cond = 1;
      if (op[3:0] == 4'h0 && (op[4] || op == 8'h80)) begin
         e.br = 1; e.tk = cond;
         e.tk_tag = (op == 8'h80) ? "R6" : "R3"; e.pc_tag = "R4";
         off = int'($signed(lo)); raw = addr + 2 + off;
         e.nxt = cond ? raw : addr + 2;
      end else if (op[3:0] == 4'h3 && (op[4] || op == 8'h83 || op == 8'h63)) begin
         e.br = 1; e.tk = cond;
         e.tk_tag = (op == 8'h83) ? "R6" : "R5"; e.pc_tag = "R5";
         if (op == 8'h63) begin
            e.push = 1; e.ret = (addr + 2) & 16'hFFFF; e.tk_tag = "R7"; e.pc_tag = "R7";
         end
         off = int'({hi, lo}); raw = addr + 2 + off;
         e.nxt = cond ? raw : addr + 3;
      end else if (op[3:0] == 4'hF) begin
         e.br = 1; e.tk = (tb[op[6:4]] == op[7]);
         e.tk_tag = "R8"; e.pc_tag = "R8";
         off = int'($signed(hi)); raw = addr + 3 + off;
         e.nxt = e.tk ? raw : addr + 3;
      end else begin
         e.tk_tag = "R9"; e.pc_tag = "R9"; e.nxt = addr;
      end
      if (e.nxt < 0 || e.nxt > 65535) e.pc_tag = "R10";
      e.nxt = e.nxt & 16'hFFFF;
      return e;
   endfunction

   task automatic compare(exp_t e);
      chk(out_valid == e.vld, "R2", "out_valid", int'(out_valid), int'(e.vld));
      if (e.vld) begin
         chk(is_branch == e.br, e.tk_tag, "is_branch", int'(is_branch), int'(e.br));
         chk(taken == e.tk, e.tk_tag, "taken", int'(taken), int'(e.tk));
         chk(int'(next_pc) == e.nxt, e.pc_tag, "next_pc", int'(next_pc), e.nxt);
         chk(push_req == e.push, "R7", "push_req", int'(push_req), int'(e.push));
         if (e.push) chk(int'(ret_addr) == e.ret, "R7", "ret_addr", int'(ret_addr), e.ret);
      end else begin
         chk(!taken && !push_req && !is_branch, "R2", "idle outputs",
             int'({is_branch, taken, push_req}), 0);
      end
   endtask

   task automatic step(bit v, logic [7:0] op, logic [7:0] lo, logic [7:0] hi, int addr,
                       logic [3:0] fl, logic [7:0] tb);
      @(negedge clk);
      if (pend.size() > 0) compare(pend.pop_front());
      in_valid = v; opcode = op; opnd_lo = lo; opnd_hi = hi; op_addr = addr[15:0];
      flag_n = fl[3]; flag_v = fl[2]; flag_z = fl[1]; flag_c = fl[0]; test_byte = tb;
      pend.push_back(model(v, op, lo, hi, addr, fl[3], fl[2], fl[1], fl[0], tb));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; in_valid = 0; opcode = 0; opnd_lo = 0; opnd_hi = 0; op_addr = 0;
      flag_n = 0; flag_v = 0; flag_z = 0; flag_c = 0; test_byte = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!out_valid && !is_branch && !taken && !push_req && next_pc == 0, "R1",
          "reset outputs", int'({out_valid, is_branch, taken, push_req}) + int'(next_pc), 0);
      rst_n = 1;
      // R1: first cycle out of reset still quiet
      @(negedge clk);
      chk(!out_valid && !taken && !push_req, "R1", "post-reset", int'(out_valid), 0);

      // all opcodes against several flag patterns and test bytes
      foreach (pend[i]) ;
      for (int op = 0; op < 256; op++) begin
         for (int k = 0; k < 4; k++) begin
            logic [3:0] fl;
            logic [7:0] tb;
            fl = (k == 0) ? 4'h0 : (k == 1) ? 4'hF : (k == 2) ? 4'hA : 4'h5;
            tb = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'h5A;
            step(1, op[7:0], 8'h10 + k[7:0], 8'hF0 - k[7:0], 16'h4000 + op * 4, fl, tb);
         end
         if (op % 16 == 7) step(0, 8'h80, 0, 0, 0, 4'h0, 8'h0);
      end

      // R10: wrap at the top and bottom of the address space
      step(1, 8'h80, 8'h7F, 8'h00, 16'hFFF0, 4'h0, 8'h0);
      step(1, 8'h80, 8'h80, 8'h00, 16'h0005, 4'h0, 8'h0);
      step(1, 8'h83, 8'h10, 8'h00, 16'hFFFF, 4'h0, 8'h0);
      step(1, 8'h63, 8'h00, 8'h80, 16'hFFFE, 4'h0, 8'h0);
      step(1, 8'h8F, 8'h00, 8'h80, 16'h0010, 4'h0, 8'h01);
      step(1, 8'h0F, 8'h00, 8'h7F, 16'hFFFC, 4'h0, 8'h00);
      // R4: short offset limits from mid memory
      step(1, 8'hF0, 8'h7F, 8'h00, 16'h8000, 4'h2, 8'h0);
      step(1, 8'hD0, 8'h80, 8'h00, 16'h8000, 4'h0, 8'h0);

      // random mix with bubbles
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 5) != 0, 8'($urandom), 8'($urandom), 8'($urandom),
              int'($urandom % 65536), 4'($urandom), 8'($urandom));
      end
      step(0, 0, 0, 0, 0, 4'h0, 8'h0);
      step(0, 0, 0, 0, 0, 4'h0, 8'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule